// File: doc/BRIEF.md
# Reloading 24-bit Down-Counter Timer

This block is a periodic tick source with a register interface. A 24-bit counter steps down by one on each enabled count cycle. After it reaches zero, the next count cycle reloads it from a programmable reload value. Each time it steps from one to zero it sets a sticky wrap flag. If interrupts are enabled, it also raises a one-clock interrupt request. A count cycle is either every core clock or only the clocks on which an external synchronous reference tick-enable is high. A control bit selects which.

Software uses a synchronous port with a read strobe, a write strobe, a word address, write data and registered read data. A read of the control word returns the wrap flag and clears it in the same access. Any write to the current-value word forces the count to zero, so the next count cycle reloads and a clean full period follows.

Top module: `tick_timer`

## Requirements
- R1: After reset the control bits, the wrap flag, the current count, the interrupt output and the read data are all zero.
- R2: Word address 0 is the control word, address 1 is the reload value and address 2 is the current count. Address 3 reads as zero. Only bits 23:0 of the reload and count words hold state; their upper bits read as zero. Read data appears on the clock after the read strobe and holds until the next read.
- R3: On each count cycle a nonzero count decreases by one, and a zero count loads the reload value, so a reload value N gives a period of N+1 count cycles.
- R4: The wrap flag (control bit 16) is set when the count steps from 1 to 0, and it stays set until it is cleared.
- R5: A read of the control word returns the current flag and clears it. A 1-to-0 step in the same cycle as that read leaves the flag set.
- R6: A write of any value to the current-count word sets the count to zero and clears the wrap flag. If a 1-to-0 step falls in the same cycle, the write wins, and neither the flag nor the interrupt results.
- R7: Control bit 0 enables counting. While it is clear, the count holds its value.
- R8: Control bit 2 selects the count source. With 1, every clock is a count cycle. With 0, only clocks with the reference tick input high are count cycles.
- R9: The interrupt output is high for exactly one clock after a 1-to-0 step taken while control bit 1 (interrupt enable) is set.
- R10: With a reload value of 0 the count stays at zero and the wrap flag is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | 2 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| refTick | input | 1 | External reference tick-enable, synchronous to clk |
| irq | output | 1 | One-clock interrupt request |

## Verification
The assertions check on every clock that:
- the count holds when no count cycle occurs and no clearing write arrives;
- a clearing write leaves a zero count, a clear flag and no interrupt;
- a zero count on a count cycle picks up the reload value;
- each interrupt is a single clock long, comes with the flag set and requires the enable that was in force.

Only the bench scenarios can show:
- the period length for a given reload value;
- the read value of the clear-on-read flag;
- the gating by the reference tick;
- reload-zero behaviour;
- the outcome of collisions between reads, writes and wraps, which the bench compares cycle by cycle against its own register model.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // word addresses of the register port
  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_RELOAD  = 1;
  localparam int ADDR_CURRENT = 2;

  // control word bit positions
  localparam int EN_BIT  = 0;
  localparam int IE_BIT  = 1;
  localparam int SRC_BIT = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic step;       // one count cycle
    logic reloadWr;   // capture a new reload value
    logic countClr;   // force count to zero
  } dpCtrl_t;

endpackage

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              hitZero
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] reloadQ;

  // step from one to zero in this cycle (clear not considered here)
  assign hitZero = dpCtrl.step && (countQ == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (dpCtrl.countClr) begin
      countQ <= '0;
    end else if (dpCtrl.step) begin
      if (countQ == '0) countQ <= reloadQ;
      else              countQ <= countQ - ONE;
    end
  end

  // reload value is not reset; software writes it before enabling
  always_ff @(posedge clk) begin
    if (dpCtrl.reloadWr) reloadQ <= wrData[CNT_W-1:0];
  end

  assign countVal  = countQ;
  assign reloadVal = reloadQ;

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.countClr |=> countQ == '0); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtrl.step && !dpCtrl.countClr) |=> $stable(countQ)); // R7

  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.step && !dpCtrl.countClr && !dpCtrl.reloadWr && countQ == '0)
      |=> countQ == $past(reloadQ)); // R3

endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int FLAG_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              refTick,
  input  logic [CNT_W-1:0]  countVal,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic              hitZero,
  output dpCtrl_t           dpCtrl,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam int PAD_W = DATA_W - CNT_W;

  logic enable, intEn, clkSel, wrapFlag;
  logic selCtrl, selReload, selCurrent;
  logic ctrlWr, ctrlRd, curWr, wrapEvent;
  logic [DATA_W-1:0] readMux;
  logic [DATA_W-1:0] ctrlWord;

  assign selCtrl    = (addr == ADDR_W'(ADDR_CTRL));
  assign selReload  = (addr == ADDR_W'(ADDR_RELOAD));
  assign selCurrent = (addr == ADDR_W'(ADDR_CURRENT));

  assign ctrlWr = wrEn && selCtrl;
  assign ctrlRd = rdEn && selCtrl;
  assign curWr  = wrEn && selCurrent;

  assign dpCtrl.step     = enable && (clkSel || refTick);
  assign dpCtrl.reloadWr = wrEn && selReload;
  assign dpCtrl.countClr = curWr;

  // a write to the count word overrides a simultaneous wrap
  assign wrapEvent = hitZero && !curWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
      intEn  <= 1'b0;
      clkSel <= 1'b0;
    end else if (ctrlWr) begin
      enable <= wrData[EN_BIT];
      intEn  <= wrData[IE_BIT];
      clkSel <= wrData[SRC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          wrapFlag <= 1'b0;
    else if (curWr)     wrapFlag <= 1'b0;
    else if (wrapEvent) wrapFlag <= 1'b1;
    else if (ctrlRd)    wrapFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= wrapEvent && intEn;
  end

  always_comb begin
    ctrlWord           = '0;
    ctrlWord[EN_BIT]   = enable;
    ctrlWord[IE_BIT]   = intEn;
    ctrlWord[SRC_BIT]  = clkSel;
    ctrlWord[FLAG_BIT] = wrapFlag;
  end

  always_comb begin
    if (selCtrl)         readMux = ctrlWord;
    else if (selReload)  readMux = {{PAD_W{1'b0}}, reloadVal};
    else if (selCurrent) readMux = {{PAD_W{1'b0}}, countVal};
    else                 readMux = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= readMux;
  end

  AST_IRQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R9

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(intEn)); // R9

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> wrapFlag); // R4

  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    curWr |=> (!wrapFlag && !irq)); // R6

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int FLAG_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              refTick,
  output logic              irq
);

  dpCtrl_t          dpCtrl;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] reloadVal;
  logic             hitZero;

  tick_timer_ctrl #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_BIT(FLAG_BIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .refTick(refTick), .countVal(countVal),
    .reloadVal(reloadVal), .hitZero(hitZero), .dpCtrl(dpCtrl),
    .rdData(rdData), .irq(irq)
  );

  tick_timer_dp #(
    .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .wrData(wrData),
    .countVal(countVal), .reloadVal(reloadVal), .hitZero(hitZero)
  );

endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        refTick = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  tick_timer dut_i (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .refTick(refTick), .irq(irq)
  );

  // bench register model
  bit        mEn, mIe, mSrc, mFlag, mIrq;
  bit [23:0] mCnt, mRel;
  bit [31:0] mRd;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] modelRead(input bit [1:0] a);
    bit [31:0] v = '0;
    case (a)
      2'd0: begin v[0] = mEn; v[1] = mIe; v[2] = mSrc; v[16] = mFlag; end
      2'd1: v = {8'h0, mRel};
      2'd2: v = {8'h0, mCnt};
      default: v = '0;
    endcase
    return v;
  endfunction

  // one clock: drive at negedge, advance model, compare at next negedge
  task automatic cyc(input bit rd, input bit wr, input bit [1:0] a,
                     input bit [31:0] d, input bit rt, input string tag);
    bit stepOk, hit, curWr;
    bit        nEn, nIe, nSrc, nFlag, nIrq;
    bit [23:0] nCnt, nRel;
    bit [31:0] nRd;
    rdEn = rd; wrEn = wr; addr = a; wrData = d; refTick = rt;
    stepOk = mEn && (mSrc || rt);
    hit    = stepOk && (mCnt == 24'd1);
    curWr  = wr && (a == 2'd2);
    nEn = mEn; nIe = mIe; nSrc = mSrc; nRel = mRel; nRd = mRd; nCnt = mCnt;
    if (wr && a == 2'd0) begin nEn = d[0]; nIe = d[1]; nSrc = d[2]; end
    if (wr && a == 2'd1) nRel = d[23:0];
    if (rd) nRd = modelRead(a);
    if (curWr) nCnt = '0;
    else if (stepOk) nCnt = (mCnt == 0) ? mRel : mCnt - 24'd1;
    if (curWr) nFlag = 0;
    else if (hit) nFlag = 1;
    else if (rd && a == 2'd0) nFlag = 0;
    else nFlag = mFlag;
    nIrq = hit && !curWr && mIe;
    @(posedge clk);
    mEn = nEn; mIe = nIe; mSrc = nSrc; mRel = nRel; mRd = nRd;
    mCnt = nCnt; mFlag = nFlag; mIrq = nIrq;
    @(negedge clk);
    rdEn = 0; wrEn = 0; refTick = 0;
    check("R9 irq", {31'b0, irq}, {31'b0, mIrq});
    if (rd) check(tag, rdData, mRd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, "idle");
  endtask

  task automatic rdReg(input bit [1:0] a, input string tag);
    cyc(1, 0, a, 0, 0, tag);
  endtask

  task automatic wrReg(input bit [1:0] a, input bit [31:0] d);
    cyc(0, 1, a, d, 0, "write");
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    bit [31:0] seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R1 rdData", rdData, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    rdReg(0, "R1 control");
    rdReg(2, "R1 count");

    // R2 width and map
    wrReg(1, 32'hFFFF_FFFF);
    rdReg(1, "R2 reload upper bits");
    check("R2 reload masked", rdData, 32'h00FF_FFFF);
    rdReg(3, "R2 unused address");
    check("R2 unused zero", rdData, 32'h0);

    // R3 period of N+1 with src=clock
    wrReg(1, 32'd3);
    wrReg(2, 32'h1234);
    wrReg(0, 32'h7);
    n = 0;
    while (!irq && n < 20) begin idle(1); n++; end
    n = 0;
    do begin idle(1); n++; end while (!irq && n < 20);
    check("R3 period", n, 32'd4);

    // R4/R5 flag set then cleared by read
    rdReg(0, "R4 flag set");
    check("R4 flag bit16", rdData[16], 32'h1);
    rdReg(0, "R5 flag cleared");

    // R6 count write clears
    idle(2);
    wrReg(2, 32'hDEAD);
    rdReg(2, "R6 count zero");
    rdReg(0, "R6 flag clear");

    // R7 hold when disabled
    wrReg(1, 32'd50);
    idle(5);
    wrReg(0, 32'h6);
    rdReg(2, "R7 held");
    idle(6);
    rdReg(2, "R7 still held");

    // R8 reference tick gating
    wrReg(2, 0);
    wrReg(0, 32'h3);
    idle(5);
    rdReg(2, "R8 no ref tick");
    cyc(0, 0, 0, 0, 1, "ref");
    cyc(0, 0, 0, 0, 1, "ref");
    rdReg(2, "R8 after ref ticks");
    check("R8 count value", rdData, 32'd49);

    // R10 reload zero
    wrReg(0, 32'h0);
    wrReg(1, 32'd0);
    wrReg(2, 0);
    rdReg(0, "R10 flag pre");
    wrReg(0, 32'h7);
    idle(10);
    rdReg(2, "R10 count stays zero");
    rdReg(0, "R10 no flag");

    // random mix: collisions of reads, writes and wraps
    for (int k = 0; k < 4000; k++) begin
      int r;
      bit rt;
      r  = $urandom_range(0, 19);
      rt = $urandom_range(0, 1);
      if (r < 5)       cyc(1, 0, 2'($urandom_range(0, 3)), 0, rt, "R3 random read");
      else if (r == 5) cyc(0, 1, 0, {$urandom} | (($urandom_range(0, 4) != 0) ? 32'h1 : 32'h0), rt, "wr");
      else if (r == 6) cyc(0, 1, 1, 32'($urandom_range(0, 9)), rt, "wr");
      else if (r == 7) cyc(0, 1, 2, $urandom, rt, "wr");
      else if (r == 8) cyc(1, 0, 0, 0, rt, "R5 random control read");
      else             cyc(0, 0, 0, 0, rt, "idle");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule